// File: doc/BRIEF.md
# Frame CRC Checker with Fault Injection

This block scans a configuration memory that is divided into fixed-size frames, one 16-bit word per clock while scanning is enabled. For every frame it builds a 16-bit CRC over the frame's words and compares it with a per-frame reference signature held in a separate signature memory. A mismatch drives the error output. The scan never stops: after the last word of a frame the next frame begins, and after the last frame it wraps back to frame 0. This holds whether or not an error was found.

To let the checker be tested without corrupting real data, a small TAP-style path loads a 21-bit fault injection register. A 10-bit instruction register selects it, serial data shifts in least significant bit first, and an update strobe copies it to an active copy. When injection is enabled for the frame being compared, one chosen bit of the computed CRC is inverted before the comparison, so that frame reports an error. The scan and all injection register writes work only while the user-mode input is high.

Top module: `frame_crc_scan`

## Requirements
- R1: While `user_mode` is high, the block reads one word per cycle at `fm_addr = frame*WORDS_PER_FRAME + word`. Its CRC uses polynomial 0x8005 (x^16+x^15+x^2+1), processes each word most significant bit first with no reflection, and restarts from 0x0000 at word 0 of every frame.
- R2: At the last word of a frame, the final CRC is compared with `sig_data`, read at `sig_addr` = current frame. `crc_err` becomes 1 on a mismatch and 0 on a match, in the cycle after the last word.
- R3: `frame_done` is a one-cycle pulse in the cycle after each frame's last word, so it comes once every WORDS_PER_FRAME enabled cycles. Frames are visited 0,1,...,NUM_FRAMES-1 and then wrap to 0.
- R4: `crc_err` keeps its value until the next `frame_done`. Scanning goes on to the next frame after an error.
- R5: While `user_mode` is low the scan is paused: addresses, CRC state and outputs do not change, and no `frame_done` occurs. Scanning resumes mid-frame once `user_mode` returns high.
- R6: `tap_ir_load` loads `tap_ir_code` (10 bits) into the instruction register. With instruction 0x015 selected, each `tap_shift` cycle shifts `tap_tdi` into bit 20 and moves the register one place toward bit 0, so data enters LSB first. `tap_tdo` shows bit 0. `tap_update` copies the shifted value to the active injection setting.
- R7: Injection field layout: bits [7:0] frame index, [11:8] bit position, [12] enable, [20:13] reserved and ignored. With the enable bit set, the chosen CRC bit is inverted only when the frame index equals the frame being compared.
- R8: `tap_shift` and `tap_update` have no effect while `user_mode` is low, or while an instruction other than 0x015 is selected.
- R9: After an update that clears the enable bit, the next frame whose comparison follows that update shows no injected error.
- R10: Reset sets `crc_err`=0, `frame_done`=0, frame and word counters to 0, and the instruction, shift and active injection registers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| user_mode | input | 1 | Enables scanning and injection register writes |
| fm_addr | output | AW | Frame memory word address |
| fm_data | input | 16 | Frame memory read data (combinational) |
| sig_addr | output | FRM_W | Signature memory address (current frame) |
| sig_data | input | 16 | Reference signature for `sig_addr` |
| tap_ir_load | input | 1 | Load instruction register |
| tap_ir_code | input | 10 | Instruction value |
| tap_shift | input | 1 | Shift strobe for the injection data register |
| tap_tdi | input | 1 | Serial data in |
| tap_update | input | 1 | Copy shifted value to the active setting |
| tap_tdo | output | 1 | Serial data out (bit 0 of shift register) |
| frame_done | output | 1 | One-cycle pulse per completed comparison |
| crc_err | output | 1 | Result of the most recent comparison |

## Verification
Assertions check on every cycle that the address advances by one per enabled cycle and wraps after the last frame, that it holds while paused, and that the error flag changes only at a frame completion. They also check that the injection registers are frozen outside user mode and that serial data lands in the top bit. Only the bench scenarios show the CRC values themselves. It sweeps every frame index and every bit position of the injection register, and runs a deliberately wrong signature, a mid-frame pause, an ignored load under a foreign instruction, and an enable cleared exactly at a frame boundary.

// File: rtl/frame_crc_pkg.sv
package frame_crc_pkg;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h8005;
  localparam int IR_W = 10;
  localparam logic [IR_W-1:0] INJ_IR_CODE = 10'h015;
  localparam int INJ_W = 21;

  // Active part of the injection setting; the reserved bits [20:13] are not kept.
  typedef struct packed {
    logic       en;
    logic [3:0] pos;
    logic [7:0] idx;
  } inj_t;

  localparam int INJ_ACT_W = $bits(inj_t);

  function automatic logic [CRC_W-1:0] crc16_word(input logic [CRC_W-1:0] seed,
                                                  input logic [CRC_W-1:0] word);
    logic [CRC_W-1:0] c;
    c = seed;
    for (int i = CRC_W - 1; i >= 0; i--) begin
      if (c[CRC_W-1] ^ word[i]) c = {c[CRC_W-2:0], 1'b0} ^ CRC_POLY;
      else                      c = {c[CRC_W-2:0], 1'b0};
    end
    return c;
  endfunction
endpackage

// File: rtl/fcs_frame_seq.sv
module fcs_frame_seq #(
  parameter int NUM_FRAMES      = 4,
  parameter int WORDS_PER_FRAME = 4,
  parameter int FRM_W           = 2,
  parameter int WRD_W           = 2,
  parameter int AW              = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [AW-1:0]    fm_addr,
  output logic [FRM_W-1:0] frame_idx,
  output logic             word_first,
  output logic             word_last
);
  logic [WRD_W-1:0] word_q, word_d;
  logic [FRM_W-1:0] frame_q, frame_d;
  logic             frame_last;

  always_comb begin
    word_last  = (word_q == WRD_W'(WORDS_PER_FRAME - 1));
    word_first = (word_q == '0);
    frame_last = (frame_q == FRM_W'(NUM_FRAMES - 1));
    word_d     = word_q;
    frame_d    = frame_q;
    if (en) begin
      if (word_last) begin
        word_d  = '0;
        frame_d = frame_last ? '0 : frame_q + 1'b1;
      end else begin
        word_d = word_q + 1'b1;
      end
    end
    fm_addr   = AW'(frame_q) * AW'(WORDS_PER_FRAME) + AW'(word_q);
    frame_idx = frame_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      frame_q <= '0;
    end else if (en) begin
      word_q  <= word_d;
      frame_q <= frame_d;
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !(word_last && frame_last)) |=> (fm_addr == $past(fm_addr) + AW'(1))); // R1
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && word_last && frame_last) |=> (fm_addr == '0)); // R3
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> $stable(fm_addr)); // R5
endmodule

// File: rtl/fcs_inject_tap.sv
module fcs_inject_tap
  import frame_crc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            user_mode,
  input  logic            ir_load,
  input  logic [IR_W-1:0] ir_code,
  input  logic            shift,
  input  logic            tdi,
  input  logic            update,
  output logic            tdo,
  output inj_t            inj
);
  logic [IR_W-1:0]  ir_q, ir_d;
  logic [INJ_W-1:0] sh_q, sh_d;
  inj_t             act_q, act_d;
  logic             dr_sel;

  always_comb begin
    dr_sel = user_mode && (ir_q == INJ_IR_CODE);
    ir_d   = ir_load ? ir_code : ir_q;
    sh_d   = (dr_sel && shift) ? {tdi, sh_q[INJ_W-1:1]} : sh_q;
    act_d  = (dr_sel && update) ? inj_t'(sh_q[INJ_ACT_W-1:0]) : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q  <= '0;
      sh_q  <= '0;
      act_q <= '0;
    end else begin
      ir_q  <= ir_d;
      sh_q  <= sh_d;
      act_q <= act_d;
    end
  end

  assign tdo = sh_q[0];
  assign inj = act_q;

  AST_FROZEN_OUTSIDE_USER: assert property (@(posedge clk) disable iff (!rst_n)
    (!user_mode) |=> ($stable(sh_q) && $stable(act_q))); // R8
  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && (ir_q == INJ_IR_CODE) && shift) |=> (sh_q[INJ_W-1] == $past(tdi))); // R6
endmodule

// File: rtl/fcs_crc_cmp.sv
module fcs_crc_cmp
  import frame_crc_pkg::*;
#(
  parameter int FRM_W           = 2,
  parameter int WORDS_PER_FRAME = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             word_first,
  input  logic             word_last,
  input  logic [CRC_W-1:0] data,
  input  logic [CRC_W-1:0] sig,
  input  logic [FRM_W-1:0] frame_idx,
  input  inj_t             inj,
  output logic             frame_done,
  output logic             crc_err
);
  logic [CRC_W-1:0] crc_q, crc_d, crc_base, crc_calc, flip_mask;
  logic             done_q, done_d, err_q, err_d, mismatch;

  always_comb begin
    crc_base  = word_first ? '0 : crc_q;
    crc_calc  = crc16_word(crc_base, data);
    flip_mask = (inj.en && (inj.idx == 8'(frame_idx))) ? (CRC_W'(1) << inj.pos) : '0;
    mismatch  = ((crc_calc ^ flip_mask) != sig);
    crc_d     = en ? crc_calc : crc_q;
    done_d    = en && word_last;
    err_d     = (en && word_last) ? mismatch : err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (en) crc_q <= crc_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign frame_done = done_q;
  assign crc_err    = err_q;

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && word_last) |=> $stable(crc_err)); // R4

  generate
    if (WORDS_PER_FRAME > 1) begin : g_pulse
      AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R3
    end
  endgenerate
endmodule

// File: rtl/frame_crc_scan.sv
module frame_crc_scan
  import frame_crc_pkg::*;
#(
  parameter int NUM_FRAMES      = 4,
  parameter int WORDS_PER_FRAME = 4,
  localparam int FRM_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int WRD_W = (WORDS_PER_FRAME > 1) ? $clog2(WORDS_PER_FRAME) : 1,
  localparam int AW    = (NUM_FRAMES * WORDS_PER_FRAME > 1) ?
                         $clog2(NUM_FRAMES * WORDS_PER_FRAME) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             user_mode,
  output logic [AW-1:0]    fm_addr,
  input  logic [15:0]      fm_data,
  output logic [FRM_W-1:0] sig_addr,
  input  logic [15:0]      sig_data,
  input  logic             tap_ir_load,
  input  logic [9:0]       tap_ir_code,
  input  logic             tap_shift,
  input  logic             tap_tdi,
  input  logic             tap_update,
  output logic             tap_tdo,
  output logic             frame_done,
  output logic             crc_err
);
  logic [FRM_W-1:0] frame_idx;
  logic             word_first, word_last;
  inj_t             inj;

  fcs_frame_seq #(
    .NUM_FRAMES(NUM_FRAMES), .WORDS_PER_FRAME(WORDS_PER_FRAME),
    .FRM_W(FRM_W), .WRD_W(WRD_W), .AW(AW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .en(user_mode), .fm_addr(fm_addr),
    .frame_idx(frame_idx), .word_first(word_first), .word_last(word_last)
  );

  fcs_inject_tap u_tap (
    .clk(clk), .rst_n(rst_n), .user_mode(user_mode), .ir_load(tap_ir_load),
    .ir_code(tap_ir_code), .shift(tap_shift), .tdi(tap_tdi), .update(tap_update),
    .tdo(tap_tdo), .inj(inj)
  );

  fcs_crc_cmp #(.FRM_W(FRM_W), .WORDS_PER_FRAME(WORDS_PER_FRAME)) u_cmp (
    .clk(clk), .rst_n(rst_n), .en(user_mode), .word_first(word_first),
    .word_last(word_last), .data(fm_data), .sig(sig_data), .frame_idx(frame_idx),
    .inj(inj), .frame_done(frame_done), .crc_err(crc_err)
  );

  assign sig_addr = frame_idx;
endmodule

// File: tb/frame_crc_scan_bench.sv
module frame_crc_scan_bench;
  localparam int NF  = 4;
  localparam int WPF = 4;

  logic        clk, rst_n, user_mode;
  logic [3:0]  fm_addr;
  logic [15:0] fm_data, sig_data;
  logic [1:0]  sig_addr;
  logic        tap_ir_load, tap_shift, tap_tdi, tap_update, tap_tdo;
  logic [9:0]  tap_ir_code;
  logic        frame_done, crc_err;

  logic [15:0] fmem [NF*WPF];
  logic [15:0] smem [NF];

  int n_vec, n_fail;
  int done_cnt, arm_after, exp_frame, en_cnt;
  logic last_err;
  logic m_en;
  logic [3:0] m_pos;
  logic [7:0] m_idx;

  assign fm_data  = fmem[fm_addr];
  assign sig_data = smem[sig_addr];

  frame_crc_scan #(.NUM_FRAMES(NF), .WORDS_PER_FRAME(WPF)) u_frame_crc_scan (
    .clk(clk), .rst_n(rst_n), .user_mode(user_mode), .fm_addr(fm_addr),
    .fm_data(fm_data), .sig_addr(sig_addr), .sig_data(sig_data),
    .tap_ir_load(tap_ir_load), .tap_ir_code(tap_ir_code), .tap_shift(tap_shift),
    .tap_tdi(tap_tdi), .tap_update(tap_update), .tap_tdo(tap_tdo),
    .frame_done(frame_done), .crc_err(crc_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] ref_crc(int f);
    logic [15:0] c;
    logic top;
    c = 16'h0000;
    for (int w = 0; w < WPF; w++) begin
      for (int b = 15; b >= 0; b--) begin
        top = c[15];
        c = c << 1;
        if (top ^ fmem[f*WPF + w][b]) c = c ^ 16'h8005;
      end
    end
    return c;
  endfunction

  function automatic logic model_err(int f);
    logic [15:0] m;
    m = (m_en && (m_idx == 8'(f))) ? (16'h0001 << m_pos) : 16'h0000;
    return ((ref_crc(f) ^ m) != smem[f]);
  endfunction

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  task automatic check(input string req, input int act, input int exp, input string what);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
    #1;
  endtask

  // Enabled-cycle counter between completions
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_cnt <= 0;
    else if (frame_done) en_cnt <= user_mode ? 1 : 0;
    else if (user_mode) en_cnt <= en_cnt + 1;
  end

  // Output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_done) begin
        check("R3", en_cnt, WPF, "enabled cycles per frame");
        check("R3", int'(sig_addr), (exp_frame + 1) % NF, "next frame after completion");
        if (done_cnt >= arm_after)
          check("R2/R7", int'(crc_err), int'(model_err(exp_frame)),
                $sformatf("crc_err for frame %0d", exp_frame));
        last_err  = crc_err;
        exp_frame = (exp_frame + 1) % NF;
        done_cnt++;
      end else begin
        check("R4", int'(crc_err), int'(last_err), "crc_err held between completions");
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  task automatic wait_dones(input int n);
    int target;
    target = done_cnt + n;
    while (done_cnt < target) tick();
  endtask

  task automatic load_ir(input logic [9:0] code);
    tap_ir_code = code;
    tap_ir_load = 1'b1;
    tick();
    tap_ir_load = 1'b0;
  endtask

  task automatic shift_dr(input logic [20:0] v);
    for (int i = 0; i < 21; i++) begin
      tap_tdi   = v[i];
      tap_shift = 1'b1;
      tick();
    end
    tap_shift = 1'b0;
    tap_tdi   = 1'b0;
  endtask

  task automatic pulse_update;
    tap_update = 1'b1;
    tick();
    tap_update = 1'b0;
  endtask

  initial begin
    logic [20:0] v;
    logic        tdo_before;
    logic [3:0]  addr_before;
    n_vec = 0; n_fail = 0; done_cnt = 0; arm_after = 0; exp_frame = 0;
    last_err = 1'b0; m_en = 1'b0; m_pos = '0; m_idx = '0;
    user_mode = 1'b0; tap_ir_load = 1'b0; tap_ir_code = '0;
    tap_shift = 1'b0; tap_tdi = 1'b0; tap_update = 1'b0;
    for (int i = 0; i < NF*WPF; i++) fmem[i] = 16'(i * 40503 + 4660) ^ {8'(i), 8'h3C};
    for (int f = 0; f < NF; f++) smem[f] = ref_crc(f);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R10 reset state
    check("R10", int'(crc_err), 0, "crc_err after reset");
    check("R10", int'(frame_done), 0, "frame_done after reset");
    check("R10", int'(fm_addr), 0, "fm_addr after reset");
    check("R10", int'(tap_tdo), 0, "tap_tdo after reset");

    // R5 no scanning while user_mode is low
    for (int k = 0; k < 10; k++) begin
      tick();
      check("R5", int'(frame_done), 0, "frame_done while paused");
      check("R5", int'(fm_addr), 0, "fm_addr while paused");
    end

    // R1/R2 clean scan over three passes
    user_mode = 1'b1;
    wait_dones(3 * NF);

    // R2/R4 wrong signature on frame 2, scanning continues
    smem[2] = smem[2] ^ 16'h0100;
    arm_after = done_cnt + 1;
    wait_dones(2 * NF);
    smem[2] = ref_crc(2);
    arm_after = done_cnt + 1;
    wait_dones(NF);

    // R6/R7 sweep of frame index and bit position
    load_ir(10'h015);
    for (int idx = 0; idx < NF; idx++) begin
      for (int pos = 0; pos < 16; pos++) begin
        v = {8'(idx * 37 + pos * 11 + 1), 1'b1, 4'(pos), 8'(idx)};
        shift_dr(v);
        check("R6", int'(tap_tdo), int'(v[0]), "tap_tdo after shift");
        pulse_update();
        m_en = 1'b1; m_pos = 4'(pos); m_idx = 8'(idx);
        arm_after = done_cnt + 1;
        wait_dones(NF + 1);
      end
    end

    // R9 enable cleared exactly at a frame boundary
    v = {8'h00, 1'b1, 4'd5, 8'd1};
    shift_dr(v);
    pulse_update();
    m_en = 1'b1; m_pos = 4'd5; m_idx = 8'd1;
    arm_after = done_cnt + 1;
    wait_dones(NF + 1);
    v = {8'hFF, 1'b0, 4'd5, 8'd1};
    shift_dr(v);
    while (!(frame_done && exp_frame == 1)) tick();
    tap_update = 1'b1;
    m_en = 1'b0;
    arm_after = done_cnt;
    tick();
    tap_update = 1'b0;
    while (!frame_done) tick();
    check("R9", int'(crc_err), 0, "frame 1 right after enable cleared");
    wait_dones(2 * NF);

    // R8/R5 writes ignored outside user mode
    user_mode = 1'b0;
    tick();
    tdo_before = tap_tdo;
    addr_before = fm_addr;
    v = {8'h00, 1'b1, 4'd3, 8'd0};
    for (int i = 0; i < 21; i++) begin
      tap_tdi = v[i]; tap_shift = 1'b1;
      tick();
      check("R5", int'(frame_done), 0, "frame_done while paused");
    end
    tap_shift = 1'b0;
    pulse_update();
    check("R8", int'(tap_tdo), int'(tdo_before), "tap_tdo after shifts outside user mode");
    check("R5", int'(fm_addr), int'(addr_before), "fm_addr held while paused");
    user_mode = 1'b1;
    wait_dones(2 * NF);

    // R8 foreign instruction
    load_ir(10'h014);
    tdo_before = tap_tdo;
    shift_dr(v);
    pulse_update();
    check("R8", int'(tap_tdo), int'(tdo_before), "tap_tdo under foreign instruction");
    wait_dones(2 * NF);
    load_ir(10'h015);

    // R5 pause in the middle of a frame
    while (!frame_done) tick();
    tick(); tick();
    user_mode = 1'b0;
    tick();
    addr_before = fm_addr;
    for (int k = 0; k < 13; k++) begin
      tick();
      check("R5", int'(frame_done), 0, "frame_done during mid-frame pause");
    end
    check("R5", int'(fm_addr), int'(addr_before), "fm_addr during mid-frame pause");
    user_mode = 1'b1;
    wait_dones(2 * NF);

    finish_run();
  end
endmodule